// File: doc/BRIEF.md
# DMA Channel Request Timeout Timer

This block watches one DMA channel and raises a timeout when the channel's peripheral has gone too long without issuing a request. A prescaler divides the system clock to produce a coarse tick. The prescaler select picks the divider, or turns the timer off. A separate threshold select sets how many ticks may pass before the timeout fires. Each request strobe restarts the measurement. Enabling the channel also restarts it.

An optional hold-off keeps the timer idle after enable until the peripheral issues its first request. This avoids false timeouts while a peripheral is still starting up. On expiry the block gives a single-cycle pulse and sets a sticky flag. It then stays quiet until a new request arrives or the channel is enabled again. Request routing, the transfer engine and interrupt merging belong to neighbouring blocks.

Top module: `chan_tmo`

## Requirements
- R1: After reset, `tmo_flag_o` and `tmo_pulse_o` are 0.
- R2: With `presc_sel_i` = 0 the timer never advances, and no pulse or flag is produced however long the channel stays enabled.
- R3: `presc_sel_i` values 1, 2 and 3 produce one tick every 2^PRE_SH1, 2^PRE_SH2 and 2^PRE_SH3 clock cycles. The defaults are 256, 65536 and 16777216.
- R4: `tmo_sel_i` code k (0..7) sets a threshold of 4·2^k ticks. Take the clock edge at which a restart event (a request, or the first enabled cycle) is sampled as edge 1. The pulse then appears after edge D·T+1, where D is the divider and T the threshold.
- R5: A request strobe clears both the prescaler phase and the tick count, so the full window restarts from that request.
- R6: With `wait_first_i` = 1 the timer stays idle after enable until the first request. From that request it times normally.
- R7: `tmo_pulse_o` lasts exactly one cycle. Afterwards the timer holds until a request or a re-enable, and a later request yields another pulse one full window later.
- R8: `tmo_flag_o` rises together with the pulse. It stays set through requests and through a disable. It clears only at the edge that samples a new enable (0 to 1).
- R9: While `en_i` is 0 the prescaler and tick count are held at zero. A re-enable therefore times a complete window, with no credit for time counted before the disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| req_i | input | 1 | Peripheral request strobe, one cycle per request |
| wait_first_i | input | 1 | Hold the timer idle until the first request after enable |
| presc_sel_i | input | 2 | Prescaler select: 0 off, 1..3 divider choice |
| tmo_sel_i | input | 3 | Threshold select, 4·2^k ticks |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_pulse_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench measures the exact edge count from a restart event to the pulse, across all three dividers and several threshold codes. A design that reused a free-running prescaler phase, or that was off by one on the compare, would miss the expected count by up to a tick. Separate scenarios cover the following cases:
- a request in mid-window, which must restart the full window rather than carry the partial count;
- a disable in mid-window, where a design that kept the old count would fire early;
- the wait-for-first-request hold-off, where a design that ignored it would fire without any request;
- the timer-off code, which must never produce a pulse or flag.

The flag is checked across requests, a disable and a re-enable, so that clearing it on a request, or never clearing it, is caught.

// File: rtl/chan_tmo_pkg.sv
package chan_tmo_pkg;
  typedef enum logic [1:0] {
    PRESC_OFF = 2'd0,
    PRESC_LO  = 2'd1,
    PRESC_MID = 2'd2,
    PRESC_HI  = 2'd3
  } presc_sel_e;

  localparam int unsigned TMO_SEL_W    = 3;
  localparam int unsigned TMO_MIN_LOG2 = 2;
  // wide enough to hold the largest threshold 2^(MIN_LOG2 + 2^SEL_W - 1)
  localparam int unsigned TICK_W       = TMO_MIN_LOG2 + (1 << TMO_SEL_W);
endpackage

// File: rtl/chan_tmo_presc.sv
module chan_tmo_presc
  import chan_tmo_pkg::*;
#(
  parameter int unsigned PRE_SH1 = 8,
  parameter int unsigned PRE_SH2 = 16,
  parameter int unsigned PRE_SH3 = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  presc_sel_e sel_i,
  output logic       tick_o
);
  localparam int unsigned PW = PRE_SH3;

  logic [PW-1:0] cnt_q, mask;

  always_comb begin
    case (sel_i)
      PRESC_LO:  mask = (PW'(1) << PRE_SH1) - PW'(1);
      PRESC_MID: mask = (PW'(1) << PRE_SH2) - PW'(1);
      PRESC_HI:  mask = (PW'(1) << PRE_SH3) - PW'(1);
      default:   mask = '0;
    endcase
  end

  assign tick_o = run_i && (sel_i != PRESC_OFF) && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + PW'(1);
  end

  // R5 / R9: a clear restarts the prescaler phase
  a_r9_presc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/chan_tmo_ticks.sv
module chan_tmo_ticks
  import chan_tmo_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 tick_i,
  input  logic [TMO_SEL_W-1:0] sel_i,
  output logic                 hit_o,
  output logic [TICK_W-1:0]    cnt_o
);
  logic [TICK_W-1:0] cnt_q, cnt_nxt, thr;

  assign thr     = TICK_W'(1) << (TMO_MIN_LOG2 + sel_i);
  assign cnt_nxt = cnt_q + TICK_W'(1);
  assign hit_o   = tick_i && (cnt_nxt == thr);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_nxt;
  end

  // R4: a hit lands the count exactly on the threshold
  a_r4_hit_at_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clr_i) |=> (cnt_q == $past(thr)));
endmodule

// File: rtl/chan_tmo.sv
module chan_tmo
  import chan_tmo_pkg::*;
#(
  parameter int unsigned PRE_SH1 = 8,
  parameter int unsigned PRE_SH2 = 16,
  parameter int unsigned PRE_SH3 = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       req_i,
  input  logic       wait_first_i,
  input  logic [1:0] presc_sel_i,
  input  logic [2:0] tmo_sel_i,
  output logic       tmo_flag_o,
  output logic       tmo_pulse_o
);
  logic en_q, armed_q, done_q, flag_q, pulse_q;
  logic restart, run, tick, hit;
  logic [TICK_W-1:0] tick_cnt;
  presc_sel_e psel;

  assign psel    = presc_sel_e'(presc_sel_i);
  // a request or the first enabled cycle restarts the window
  assign restart = !en_i || !en_q || req_i;
  assign run     = !restart && (armed_q || !wait_first_i) && !done_q
                   && (psel != PRESC_OFF);

  chan_tmo_presc #(
    .PRE_SH1(PRE_SH1), .PRE_SH2(PRE_SH2), .PRE_SH3(PRE_SH3)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .run_i (run),
    .sel_i (psel),
    .tick_o(tick)
  );

  chan_tmo_ticks u_ticks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .tick_i(tick),
    .sel_i (tmo_sel_i),
    .hit_o (hit),
    .cnt_o (tick_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        armed_q <= 1'b0;
        done_q  <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        pulse_q <= hit;
        if (!en_q) begin
          flag_q  <= 1'b0;
          armed_q <= 1'b0;
          done_q  <= 1'b0;
        end
        if (req_i) begin
          armed_q <= 1'b1;
          done_q  <= 1'b0;
        end else if (hit) begin
          done_q <= 1'b1;
          flag_q <= 1'b1;
        end
      end
    end
  end

  assign tmo_flag_o  = flag_q;
  assign tmo_pulse_o = pulse_q;

  a_r7_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_pulse_o |=> !tmo_pulse_o);

  a_r8_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_pulse_o |-> tmo_flag_o);

  a_r8_flag_clears_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmo_flag_o) |-> ($past(en_i) && !$past(en_q)));

  a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tick_cnt == '0));

  a_r2_off_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel == PRESC_OFF) |-> !hit);
endmodule

// File: tb/chan_tmo_tb.sv
module chan_tmo_tb;
  localparam int SH1 = 2, SH2 = 3, SH3 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, req = 1'b0, wfirst = 1'b0;
  logic [1:0] psel = 2'd1;
  logic [2:0] tsel = 3'd0;
  logic flag, pulse;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  chan_tmo #(.PRE_SH1(SH1), .PRE_SH2(SH2), .PRE_SH3(SH3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .req_i(req),
    .wait_first_i(wfirst), .presc_sel_i(psel), .tmo_sel_i(tsel),
    .tmo_flag_o(flag), .tmo_pulse_o(pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int window(input int p, input int t);
    int sh;
    sh = (p == 1) ? SH1 : (p == 2) ? SH2 : SH3;
    return (1 << sh) * (4 << t);
  endfunction

  // stimulus already applied at a negedge; count edges until pulse seen
  task automatic measure(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      if (pulse) begin n = i; break; end
    end
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulse) seen++;
    end
  endtask

  task automatic disable_ch();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(flag == 1'b0, "R1 flag after reset", flag, 0);
    chk(pulse == 1'b0, "R1 pulse after reset", pulse, 0);
  endtask

  task automatic t_window(input int p, input int t);
    int n, seen, w;
    disable_ch();
    psel = 2'(p); tsel = 3'(t); wfirst = 1'b0;
    en = 1'b1;
    w = window(p, t);
    measure(w + 50, n);
    chk(n == w + 1, $sformatf("R3_R4 window p=%0d t=%0d", p, t), n, w + 1);
    chk(flag == 1'b1, "R8 flag set with pulse", flag, 1);
    @(negedge clk);
    chk(pulse == 1'b0, "R7 pulse one cycle", pulse, 0);
    quiet(2 * w, seen);
    chk(seen == 0, "R7 holds after timeout", seen, 0);
  endtask

  task automatic t_off();
    int seen;
    disable_ch();
    psel = 2'd0; tsel = 3'd0; en = 1'b1;
    quiet(3000, seen);
    chk(seen == 0, "R2 prescaler off no pulse", seen, 0);
    chk(flag == 1'b0, "R2 prescaler off no flag", flag, 0);
  endtask

  task automatic t_req_restart();
    int n, w;
    disable_ch();
    psel = 2'd1; tsel = 3'd0; en = 1'b1;
    w = window(1, 0);
    repeat (10) @(negedge clk);
    chk(pulse == 1'b0, "R5 no early pulse", pulse, 0);
    req = 1'b1;
    measure(w + 50, n);
    chk(n == w + 1, "R5 request restarts window", n, w + 1);
  endtask

  task automatic t_wait_first();
    int n, seen, w;
    disable_ch();
    psel = 2'd1; tsel = 3'd0; wfirst = 1'b1; en = 1'b1;
    w = window(1, 0);
    quiet(200, seen);
    chk(seen == 0, "R6 idle before first request", seen, 0);
    chk(flag == 1'b0, "R6 no flag before first request", flag, 0);
    req = 1'b1;
    measure(w + 50, n);
    chk(n == w + 1, "R6 times from first request", n, w + 1);
    wfirst = 1'b0;
  endtask

  task automatic t_retrigger();
    int n, w;
    disable_ch();
    psel = 2'd2; tsel = 3'd1; en = 1'b1;
    w = window(2, 1);
    measure(w + 50, n);
    chk(n == w + 1, "R7 first timeout", n, w + 1);
    repeat (5) @(negedge clk);
    req = 1'b1;
    measure(w + 50, n);
    chk(n == w + 1, "R7 request rearms timeout", n, w + 1);
  endtask

  task automatic t_flag_sticky();
    int n, w;
    disable_ch();
    psel = 2'd1; tsel = 3'd0; en = 1'b1;
    w = window(1, 0);
    measure(w + 50, n);
    chk(flag == 1'b1, "R8 flag set", flag, 1);
    req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk(flag == 1'b1, "R8 flag survives request", flag, 1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(flag == 1'b1, "R8 flag survives disable", flag, 1);
    en = 1'b1;
    @(negedge clk);
    chk(flag == 1'b0, "R8 flag cleared on enable", flag, 0);
  endtask

  task automatic t_disable_clear();
    int n, w;
    disable_ch();
    psel = 2'd1; tsel = 3'd0; en = 1'b1;
    w = window(1, 0);
    repeat (12) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    measure(w + 50, n);
    chk(n == w + 1, "R9 disable clears progress", n, w + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window(1, 0);
    t_window(1, 3);
    t_window(1, 7);
    t_window(2, 1);
    t_window(3, 2);
    t_off();
    t_req_restart();
    t_wait_first();
    t_retrigger();
    t_flag_sticky();
    t_disable_clear();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule